// File: doc/BRIEF.md
# L1 Sharing Tracker

This block is a set-associative directory that records which of the private L1 caches currently hold a copy of each L1-sized line. When an L1 misses, the requesting unit looks the line up here. On a hit the block names another unit whose L1 can supply the line. On a miss the request goes on to the shared L2. The block keeps no coherence state. Each entry holds a tag and a bitmask of sharers, with one bit per compute unit.

The entries change through four commands: adding a sharer when a line fill completes, dropping a sharer when an L1 evicts the line, killing the whole entry when a write-through or coherent operation touches the line, and flushing every entry at a global synchronization point. A write kills the entry no matter which unit issued it. A unit that wrote a line therefore can never be directed to a stale copy held by another unit. Other caches are sent no invalidations.

Commands arrive on one valid/ready port, one per cycle. Each lookup produces exactly one response on a valid/ready response port. The storage is split into address-interleaved banks. Each bank has its own ways, a tree pseudo-LRU and a rotating sharer pointer per entry.

Top module: `l1_share_dir`

## Requirements
- R1: A command address is split as follows: bits [6:0] are the byte offset within a 128-byte line and are ignored; bits [9:7] select one of 8 banks; the next log2(SETS/BANKS) bits select the set inside the bank; the remaining upper bits are the tag. Addresses within one line refer to the same entry; lines in different banks never alias.
- R2: A lookup (cmd_op=0) returns rsp_hit=1 only when a valid entry for the line exists and its mask contains at least one unit other than the requester; rsp_sharer is then a unit whose bit is set and which is not the requester. Otherwise rsp_hit=0 and rsp_sharer=0.
- R3: Among the eligible sharers, a hitting lookup picks the lowest-numbered unit above the entry's pointer, or else the lowest-numbered eligible unit. The chosen unit becomes the new pointer. A newly allocated entry's pointer is the unit that created it.
- R4: An add (cmd_op=1) with cmd_alloc=1 sets the unit's bit, creating the entry if needed. An add with cmd_alloc=0 has no effect.
- R5: A drop (cmd_op=2) clears the unit's bit in a matching entry. An entry whose mask becomes zero becomes invalid. No valid entry ever has an empty mask.
- R6: A kill (cmd_op=3) from any unit invalidates the matching entry and all of its sharers.
- R7: A flush (cmd_op=4) invalidates every entry in every bank in one cycle, whatever address it carries.
- R8: An add that misses fills the lowest-numbered invalid way of the set. If the set is full, it fills the way named by a binary-tree pseudo-LRU, where a node bit of 0 points to the lower half. Adds and hitting lookups mark their way most recently used. Misses, drops and kills do not.
- R9: Each accepted lookup produces one response on the following cycle. The response stays valid and unchanged until rsp_ready is high. cmd_ready is low only while a response is waiting. Other commands produce no response.
- R10: After reset no entry is valid, rsp_valid is 0 and cmd_ready is 1.
- R11: Repeated adds of the same line never create a second entry. A single drop by the only sharer removes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | 0 lookup, 1 add, 2 drop, 3 kill, 4 flush |
| cmd_addr | input | ADDR_W | Byte address of the line |
| cmd_unit | input | log2(UNITS) | Issuing compute unit |
| cmd_alloc | input | 1 | Add may allocate (the fill was cacheable) |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | A remote sharer was found |
| rsp_sharer | output | log2(UNITS) | Unit chosen to serve the line |

## Verification
The assertions watch invariants on every cycle. They check that one line never occupies two ways and that no valid entry has an empty mask. They also check that a hit never names the requester or a unit missing from the mask, that a fill never displaces a live way while a free way exists, that a flush leaves nothing to match, and that a stalled response holds still. Some behaviours only show up in the bench's scenarios, which compare every lookup against a reference model. These are the exact rotation order among sharers, the choice of victim under pseudo-LRU once a set is full, the effect of disallowed adds, and the invalidation of whole entries by kills and flushes.

// File: rtl/l1sd_pkg.sv
package l1sd_pkg;
   typedef enum logic [2:0] {
      OP_LOOKUP = 3'd0,
      OP_ADD    = 3'd1,
      OP_DROP   = 3'd2,
      OP_KILL   = 3'd3,
      OP_FLUSH  = 3'd4
   } sd_op_e;
endpackage

// File: rtl/l1sd_pick.sv
// Rotating choice among eligible sharers: first set bit above ptr, else lowest.
module l1sd_pick #(
   parameter int UNITS = 16,
   localparam int UNIT_W = $clog2(UNITS)
) (
   input  logic [UNITS-1:0]  cand_i,
   input  logic [UNIT_W-1:0] ptr_i,
   output logic              found_o,
   output logic [UNIT_W-1:0] choice_o
);
   logic              hi_found;
   logic [UNIT_W-1:0] hi_idx, lo_idx;

   always_comb begin
      hi_found = 1'b0;
      found_o  = 1'b0;
      hi_idx   = '0;
      lo_idx   = '0;
      for (int i = UNITS-1; i >= 0; i--) begin
         if (cand_i[i]) begin
            found_o = 1'b1;
            lo_idx  = UNIT_W'(i);
            if (i > int'(ptr_i)) begin
               hi_found = 1'b1;
               hi_idx   = UNIT_W'(i);
            end
         end
      end
      choice_o = hi_found ? hi_idx : lo_idx;
   end
endmodule

// File: rtl/l1sd_plru.sv
// Binary-tree pseudo-LRU: victim walk and most-recently-used update.
module l1sd_plru #(
   parameter int WAYS = 8,
   localparam int LVL = $clog2(WAYS)
) (
   input  logic [WAYS-2:0] tree_i,
   input  logic [LVL-1:0]  touch_i,
   output logic [LVL-1:0]  victim_o,
   output logic [WAYS-2:0] tree_o
);
   always_comb begin
      int node;
      node     = 0;
      victim_o = '0;
      for (int l = 0; l < LVL; l++) begin
         victim_o[LVL-1-l] = tree_i[node];
         node = 2*node + 1 + int'(tree_i[node]);
      end
   end

   always_comb begin
      int node;
      node   = 0;
      tree_o = tree_i;
      for (int l = 0; l < LVL; l++) begin
         tree_o[node] = ~touch_i[LVL-1-l];
         node = 2*node + 1 + int'(touch_i[LVL-1-l]);
      end
   end
endmodule

// File: rtl/l1sd_bank.sv
module l1sd_bank
   import l1sd_pkg::*;
#(
   parameter int UNITS = 16,
   parameter int WAYS  = 8,
   parameter int SETS  = 16,
   parameter int TAG_W = 18,
   localparam int UNIT_W = $clog2(UNITS),
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              flush,
   input  sd_op_e            op,
   input  logic [SET_W-1:0]  set_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic [UNIT_W-1:0] unit_i,
   input  logic              alloc_i,
   output logic              hit_o,
   output logic [UNIT_W-1:0] sharer_o
);
   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic [UNITS-1:0]  mask_q [SETS][WAYS];
   logic [UNIT_W-1:0] ptr_q  [SETS][WAYS];
   logic [WAYS-1:0]   vld_q  [SETS];
   logic [WAYS-2:0]   plru_q [SETS];

   logic [WAYS-1:0]   row_vld, match;
   logic              any_match, free_found, found;
   logic [WAY_W-1:0]  hit_way, free_way, fill_way, touch_way, plru_victim;
   logic [UNITS-1:0]  cur_mask, bit_u, cand, drop_mask;
   logic [UNIT_W-1:0] cur_ptr, choice;
   logic [WAYS-2:0]   tree_next;
   logic              is_lk, is_add, is_drop, is_kill;
   logic              do_touch, do_fill, do_or, do_drop, do_clear;

   assign row_vld = vld_q[set_i];

   always_comb begin
      for (int w = 0; w < WAYS; w++)
         match[w] = row_vld[w] && (tag_q[set_i][w] == tag_i);
   end

   always_comb begin
      any_match  = 1'b0;
      free_found = 1'b0;
      hit_way    = '0;
      free_way   = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (match[w]) begin
            any_match = 1'b1;
            hit_way   = WAY_W'(w);
         end
         if (!row_vld[w]) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
   end

   assign cur_mask  = mask_q[set_i][hit_way];
   assign cur_ptr   = ptr_q[set_i][hit_way];
   assign bit_u     = UNITS'(1) << unit_i;
   assign cand      = cur_mask & ~bit_u;
   assign drop_mask = cur_mask & ~bit_u;

   l1sd_pick #(.UNITS(UNITS)) u_pick (
      .cand_i  (cand),
      .ptr_i   (cur_ptr),
      .found_o (found),
      .choice_o(choice)
   );

   assign fill_way  = free_found ? free_way : plru_victim;
   assign touch_way = any_match ? hit_way : fill_way;

   l1sd_plru #(.WAYS(WAYS)) u_plru (
      .tree_i  (plru_q[set_i]),
      .touch_i (touch_way),
      .victim_o(plru_victim),
      .tree_o  (tree_next)
   );

   assign hit_o    = any_match && found;
   assign sharer_o = hit_o ? choice : '0;

   assign is_lk    = sel && (op == OP_LOOKUP);
   assign is_add   = sel && (op == OP_ADD) && alloc_i;
   assign is_drop  = sel && (op == OP_DROP);
   assign is_kill  = sel && (op == OP_KILL);
   assign do_touch = (is_lk && hit_o) || is_add;
   assign do_fill  = is_add && !any_match;
   assign do_or    = is_add && any_match;
   assign do_drop  = is_drop && any_match;
   assign do_clear = (is_kill && any_match) || (do_drop && (drop_mask == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]  <= '0;
            plru_q[s] <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (do_fill)  vld_q[set_i][fill_way] <= 1'b1;
         if (do_clear) vld_q[set_i][hit_way]  <= 1'b0;
         if (do_touch) plru_q[set_i]          <= tree_next;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         tag_q[set_i][fill_way]  <= tag_i;
         mask_q[set_i][fill_way] <= bit_u;
         ptr_q[set_i][fill_way]  <= unit_i;
      end
      if (do_or)            mask_q[set_i][hit_way] <= cur_mask | bit_u;
      if (do_drop)          mask_q[set_i][hit_way] <= drop_mask;
      if (is_lk && hit_o)   ptr_q[set_i][hit_way]  <= choice;
   end

   // R11
   single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R2
   remote_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (choice != unit_i) && cur_mask[choice]);

   // R8
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_add && !any_match && !(&row_vld)) |-> !row_vld[fill_way]);

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !any_match);

   for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
      // R5
      live_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         row_vld[w] |-> (mask_q[set_i][w] != '0));
   end
endmodule

// File: rtl/l1_share_dir.sv
module l1_share_dir
   import l1sd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int UNITS      = 16,
   parameter int LINE_BYTES = 128,
   parameter int BANKS      = 8,
   parameter int SETS       = 128,
   parameter int WAYS       = 8,
   localparam int UNIT_W    = $clog2(UNITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [UNIT_W-1:0] cmd_unit,
   input  logic              cmd_alloc,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_hit,
   output logic [UNIT_W-1:0] rsp_sharer
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int BANK_W = $clog2(BANKS);
   localparam int SPB    = SETS / BANKS;
   localparam int SET_W  = $clog2(SPB);
   localparam int TAG_W  = ADDR_W - OFF_W - BANK_W - SET_W;

   if (BANKS < 2 || (BANKS & (BANKS-1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (SPB < 2 || (SPB & (SPB-1)) != 0 || SPB * BANKS != SETS) begin : g_bad_sets
      $error("SETS/BANKS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS-1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (UNITS < 2 || (LINE_BYTES & (LINE_BYTES-1)) != 0 || TAG_W < 1) begin : g_bad_geom
      $error("UNITS, LINE_BYTES or ADDR_W out of range");
   end

   sd_op_e            op;
   logic              fire, is_flush;
   logic [BANK_W-1:0] bank_idx;
   logic [SET_W-1:0]  set_idx;
   logic [TAG_W-1:0]  tag;
   logic [BANKS-1:0]  hit_b;
   logic [UNIT_W-1:0] sharer_b [BANKS];
   logic              unused_offset;

   assign op            = sd_op_e'(cmd_op);
   assign bank_idx      = cmd_addr[OFF_W +: BANK_W];
   assign set_idx       = cmd_addr[OFF_W+BANK_W +: SET_W];
   assign tag           = cmd_addr[ADDR_W-1 -: TAG_W];
   assign unused_offset = ^cmd_addr[OFF_W-1:0];

   assign cmd_ready = !rsp_valid || rsp_ready;
   assign fire      = cmd_valid && cmd_ready;
   assign is_flush  = fire && (op == OP_FLUSH);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      l1sd_bank #(
         .UNITS(UNITS), .WAYS(WAYS), .SETS(SPB), .TAG_W(TAG_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (fire && (op != OP_FLUSH) && (bank_idx == BANK_W'(b))),
         .flush   (is_flush),
         .op      (op),
         .set_i   (set_idx),
         .tag_i   (tag),
         .unit_i  (cmd_unit),
         .alloc_i (cmd_alloc),
         .hit_o   (hit_b[b]),
         .sharer_o(sharer_b[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_sharer <= '0;
      end else if (fire && (op == OP_LOOKUP)) begin
         rsp_valid  <= 1'b1;
         rsp_hit    <= hit_b[bank_idx];
         rsp_sharer <= sharer_b[bank_idx];
      end else if (rsp_ready) begin
         rsp_valid  <= 1'b0;
      end
   end

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_sharer));

   // R9
   lookup_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_LOOKUP)) |=> rsp_valid);

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_sharer == '0));
endmodule

// File: tb/l1_share_dir_test.sv
module l1_share_dir_test;
   import l1sd_pkg::*;
   localparam int UNITS = 16, BANKS = 8, SETS = 128, WAYS = 8, SPB = SETS/BANKS;
   localparam int NENT = SETS*WAYS;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_ready, cmd_alloc = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [3:0]  cmd_unit = '0;
   logic        rsp_valid, rsp_ready = 1'b1, rsp_hit;
   logic [3:0]  rsp_sharer;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   l1_share_dir uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_unit(cmd_unit), .cmd_alloc(cmd_alloc),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_sharer(rsp_sharer)
   );

   // reference model
   logic [17:0] m_tag  [NENT];
   logic [15:0] m_mask [NENT];
   bit          m_vld  [NENT];
   int          m_ptr  [NENT];
   logic [6:0]  m_plru [SETS];

   function automatic logic [31:0] mk(int b, int s, int t, int off);
      return {t[17:0], s[3:0], b[2:0], off[6:0]};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic m_touch(int r, int w);
      int node = 0;
      for (int l = 2; l >= 0; l--) begin
         int bt = (w >> l) & 1;
         m_plru[r][node] = (bt == 0);
         node = 2*node + 1 + bt;
      end
   endtask

   function automatic int m_victim(int r);
      int node = 0, v = 0;
      for (int l = 0; l < 3; l++) begin
         int bt = int'(m_plru[r][node]);
         v = (v << 1) | bt;
         node = 2*node + 1 + bt;
      end
      return v;
   endfunction

   task automatic m_apply(int op, int b, int s, int t, int u, bit alloc,
                          output bit hit, output int sh);
      int r = b*SPB + s;
      int w = -1;
      hit = 0; sh = 0;
      for (int k = 0; k < WAYS; k++)
         if (w < 0 && m_vld[r*WAYS+k] && m_tag[r*WAYS+k] == 18'(t)) w = k;
      case (op)
         0: if (w >= 0) begin
               logic [15:0] cand = m_mask[r*WAYS+w] & ~(16'(1) << u);
               if (cand != 0) begin
                  for (int k = 16; k >= 1; k--) begin
                     int i = (m_ptr[r*WAYS+w] + k) % 16;
                     if (cand[i]) sh = i;
                  end
                  hit = 1;
                  m_ptr[r*WAYS+w] = sh;
                  m_touch(r, w);
               end
            end
         1: if (alloc) begin
               if (w >= 0) begin
                  m_mask[r*WAYS+w] |= 16'(1) << u;
                  m_touch(r, w);
               end else begin
                  int fw = -1;
                  for (int k = 0; k < WAYS; k++)
                     if (fw < 0 && !m_vld[r*WAYS+k]) fw = k;
                  if (fw < 0) fw = m_victim(r);
                  m_vld[r*WAYS+fw]  = 1;
                  m_tag[r*WAYS+fw]  = 18'(t);
                  m_mask[r*WAYS+fw] = 16'(1) << u;
                  m_ptr[r*WAYS+fw]  = u;
                  m_touch(r, fw);
               end
            end
         2: if (w >= 0) begin
               m_mask[r*WAYS+w] &= ~(16'(1) << u);
               if (m_mask[r*WAYS+w] == 0) m_vld[r*WAYS+w] = 0;
            end
         3: if (w >= 0) m_vld[r*WAYS+w] = 0;
         4: for (int k = 0; k < NENT; k++) m_vld[k] = 0;
         default: ;
      endcase
   endtask

   // drive one command at the current negedge, check at the next negedge
   task automatic send(int op, int b, int s, int t, int u, bit alloc, string req, int off = 0);
      bit hit; int sh;
      cmd_op = 3'(op); cmd_addr = mk(b, s, t, off); cmd_unit = 4'(u);
      cmd_alloc = alloc; cmd_valid = 1'b1;
      chk(cmd_ready == 1'b1, "R9", "cmd_ready", int'(cmd_ready), 1);
      @(posedge clk);
      m_apply(op, b, s, t, u, alloc, hit, sh);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (op == 0) begin
         chk(rsp_valid == 1'b1, "R9", "rsp_valid", int'(rsp_valid), 1);
         chk({rsp_hit, rsp_sharer} == {hit, 4'(sh)}, req, "hit/sharer",
             int'({rsp_hit, rsp_sharer}), int'({hit, 4'(sh)}));
      end else begin
         chk(rsp_valid == 1'b0, "R9", "no response", int'(rsp_valid), 0);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int k = 0; k < NENT; k++) begin m_vld[k] = 0; m_ptr[k] = 0; m_mask[k] = 0; m_tag[k] = 0; end
      for (int k = 0; k < SETS; k++) m_plru[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(cmd_ready == 1'b1, "R10", "cmd_ready", int'(cmd_ready), 1);
      chk(rsp_valid == 1'b0, "R10", "rsp_valid", int'(rsp_valid), 0);
      send(0, 1, 2, 33, 4, 0, "R10");

      // R2 own bit excluded, remote sharer found
      send(1, 1, 2, 33, 3, 1, "R2");
      send(0, 1, 2, 33, 3, 0, "R2");
      send(0, 1, 2, 33, 5, 0, "R2");
      // R4 disallowed add ignored
      send(1, 1, 2, 33, 7, 0, "R4");
      send(0, 1, 2, 33, 3, 0, "R4");
      // R3 rotation over sharers 3, 7, 9
      send(1, 1, 2, 33, 7, 1, "R3");
      send(1, 1, 2, 33, 9, 1, "R3");
      for (int k = 0; k < 5; k++) send(0, 1, 2, 33, 0, 0, "R3");
      send(0, 1, 2, 33, 9, 0, "R3");
      // R1 offset ignored, other bank does not alias
      send(0, 1, 2, 33, 0, 0, "R1", 100);
      send(0, 6, 2, 33, 0, 0, "R1");
      send(0, 1, 3, 33, 0, 0, "R1");
      // R5 drops empty the entry
      send(2, 1, 2, 33, 3, 0, "R5");
      send(0, 1, 2, 33, 0, 0, "R5");
      send(2, 1, 2, 33, 7, 0, "R5");
      send(2, 1, 2, 33, 9, 0, "R5");
      send(0, 1, 2, 33, 0, 0, "R5");
      // R6 kill by a non-sharer
      send(1, 4, 7, 90, 2, 1, "R6");
      send(1, 4, 7, 90, 8, 1, "R6");
      send(3, 4, 7, 90, 6, 0, "R6");
      send(0, 4, 7, 90, 1, 0, "R6");
      // R11 repeated add then single drop
      send(1, 2, 1, 55, 5, 1, "R11");
      send(1, 2, 1, 55, 5, 1, "R11");
      send(2, 2, 1, 55, 5, 0, "R11");
      send(0, 2, 1, 55, 0, 0, "R11");
      // R8 fill a set, touch, overflow
      for (int t = 100; t < 108; t++) send(1, 3, 5, t, 1, 1, "R8");
      send(0, 3, 5, 100, 2, 0, "R8");
      send(0, 3, 5, 105, 2, 0, "R8");
      send(1, 3, 5, 108, 1, 1, "R8");
      send(1, 3, 5, 109, 1, 1, "R8");
      for (int t = 100; t < 110; t++) send(0, 3, 5, t, 2, 0, "R8");
      // R7 flush empties everything
      send(1, 0, 0, 12, 1, 1, "R7");
      send(4, 5, 9, 0, 0, 0, "R7");
      send(0, 0, 0, 12, 2, 0, "R7");
      send(0, 3, 5, 100, 2, 0, "R7");

      // R9 stalled response
      send(1, 7, 4, 21, 6, 1, "R9");
      rsp_ready = 1'b0;
      begin
         bit hit; int sh;
         cmd_op = 3'(0); cmd_addr = mk(7, 4, 21, 0); cmd_unit = 4'd1; cmd_valid = 1'b1;
         @(posedge clk);
         m_apply(0, 7, 4, 21, 1, 0, hit, sh);
         @(negedge clk);
         chk(cmd_ready == 1'b0, "R9", "stall ready", int'(cmd_ready), 0);
         chk(rsp_valid && rsp_hit == hit && rsp_sharer == 4'(sh), "R9", "stall rsp",
             int'({rsp_valid, rsp_hit, rsp_sharer}), int'({1'b1, hit, 4'(sh)}));
         @(negedge clk);
         chk(rsp_valid && rsp_hit == hit && rsp_sharer == 4'(sh), "R9", "held rsp",
             int'({rsp_valid, rsp_hit, rsp_sharer}), int'({1'b1, hit, 4'(sh)}));
         cmd_valid = 1'b0;
         rsp_ready = 1'b1;
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R9", "drained", int'(rsp_valid), 0);
         chk(cmd_ready == 1'b1, "R9", "ready back", int'(cmd_ready), 1);
      end

      // random mix on a few crowded sets
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 100);
         int op = (r < 35) ? 0 : (r < 75) ? 1 : (r < 85) ? 2 : (r < 99) ? 3 : 4;
         int b  = ($urandom % 2 == 0) ? 0 : 5;
         int s  = ($urandom % 2 == 0) ? 0 : 15;
         int t  = int'($urandom % 12);
         int u  = int'($urandom % 6);
         bit al = ($urandom % 8) != 0;
         send(op, b, s, t, u, al, (op == 0) ? "R2/R3/R8" : "R9", int'($urandom % 128));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule